// File: doc/BRIEF.md
# Quadrature Snapshot Counter

This block is one 32-bit counting channel. It takes its count pulses from one of three sources: a two-phase incremental encoder decoded at four counts per cycle, a single pulse line with a separate direction line, or an internal tick that counts down and stops at zero. Two reload values and two match values are held at the ports. A selectable index signal can reload the counter. A permissive control can limit reloads to moments when the counter is idle, which gives one-shot pulse behaviour.

When an enabled event occurs, a capture engine records three things together: the counter value after that edge, a free-running 32-bit cycle stamp, and a bitmask that names every cause. The events are an index rising edge, a compare match, reaching zero, an illegal encoder transition, and a software-forced capture. Captures go into a small queue that a reader drains one entry at a time. Each hardware event enable is either held or consumed by its first capture.

Top module: `qcnt_channel`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `rd_valid` is 0 and `overflow` is 0.
- R2: With `clk_mode`=0 (encoder), the phase pair {B, A^B} forms a 2-bit position. The count goes up by one when this position advances by one step modulo 4 and goes down by one when it moves back by one step. Phase A leading phase B therefore counts up, and the count wraps modulo 2^32.
- R3: In encoder mode, a transition in which both phases change in one cycle leaves the count unchanged and raises reason bit 3. In the other clock modes such a transition is never flagged as an error.
- R4: With `clk_mode`=1 (single-phase), every rising edge of `phase_a` counts up when `phase_b`=0 and counts down when `phase_b`=1. No other edge changes the count.
- R5: With `clk_mode`=2 (internal), each cycle with `tick`=1 counts down by one. The count holds at 0 instead of wrapping. A counting step that lands on 0 raises reason bit 2.
- R6: `pl_trig`=1 reloads on reaching zero and `pl_trig`=2 reloads on an index rising edge. The reload value comes from `preload0` after reset. When `pl_alt`=1, the source swaps between `preload0` and `preload1` after every reload.
- R7: With `pl_permissive`=0, a reload may happen at any time. With `pl_permissive`=1, a reload is taken only when the count is 0 or the same step reaches 0. Otherwise the count is unchanged.
- R8: A counting step whose new value equals `cmp1` (when `cmp_sel`=1) or `cmp0` (when `cmp_sel`=0) raises reason bit 1. The unselected register raises nothing.
- R9: The index source `ix_src` selects as follows: 0 is `index_ext`, 1 is the inverse of `index_ext`, and 2 to 7 are `peer_out[0]` to `peer_out[5]`. A rising edge of the selected signal raises reason bit 0. Unselected sources have no effect.
- R10: `force_snap`=1 captures an entry with reason bit 4 in that cycle, whether or not the channel is running and whatever the arming.
- R11: A capture stores the count after the same edge, the free-running stamp (one per cycle), and a reason mask that is never zero. The stamp difference between two captures equals the number of cycles between them.
- R12: Pulsing `snap_load` copies `snap_en` into the armed set. A fired bit whose `snap_sticky` bit is 0 is disarmed by its capture, and a sticky bit stays armed.
- R13: While `run`=0, the count, reload selection and armed set do not change. Index edges, ticks and phase changes are ignored.
- R14: The queue holds 16 entries. A capture arriving when the queue is full is dropped and sets `overflow`. `overflow` clears on the next read. `rd_en` with `rd_valid`=1 pops the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = channel counts and reacts to events |
| clk_mode | input | 2 | 0 encoder, 1 single-phase, 2 internal tick |
| phase_a | input | 1 | Encoder phase A / pulse line (synchronized) |
| phase_b | input | 1 | Encoder phase B / direction line (synchronized) |
| tick | input | 1 | Internal count-down strobe |
| index_ext | input | 1 | External index signal |
| peer_out | input | 6 | Outputs of neighbouring channels, usable as index |
| ix_src | input | 3 | Index source select |
| pl_trig | input | 2 | Reload trigger: 0 none, 1 zero reached, 2 index edge |
| pl_alt | input | 1 | Swap reload source after each reload |
| pl_permissive | input | 1 | 1 = reload only while idle at zero |
| preload0 | input | 32 | First reload value |
| preload1 | input | 32 | Second reload value |
| cmp0 | input | 32 | First match value |
| cmp1 | input | 32 | Second match value |
| cmp_sel | input | 1 | Selects the active match value |
| snap_en | input | 4 | Enables for hardware events (bit order as reasons 0..3) |
| snap_sticky | input | 4 | 1 = enable survives its capture |
| snap_load | input | 1 | Strobe: load `snap_en` into the armed set |
| force_snap | input | 1 | Capture now |
| rd_en | input | 1 | Pop the queue head |
| count | output | 32 | Current count |
| rd_valid | output | 1 | Queue not empty |
| rd_count | output | 32 | Head entry count |
| rd_stamp | output | 32 | Head entry stamp |
| rd_reason | output | 5 | Head entry reason mask |
| overflow | output | 1 | A capture was dropped since the last read |

## Verification
The hardest case to reach from the ports is an illegal encoder transition. It needs both phases to move in the same cycle, which a normal encoder never produces. The stimulus drives the phase pair straight from 00 to 11 and back, then repeats the same double change in single-phase mode to show that it is not flagged there. Reaching a full queue with dropped entries needs a run of captures faster than any hardware event. Holding the forced capture for more cycles than the queue depth gets there and shows the stamps of the surviving entries to be consecutive.

// File: rtl/qcnt_pkg.sv
// Shared encodings for the quadrature snapshot counter.
package qcnt_pkg;
    typedef enum logic [1:0] {
        CLK_QUAD   = 2'd0,
        CLK_SINGLE = 2'd1,
        CLK_TICK   = 2'd2
    } clk_mode_e;

    typedef enum logic [1:0] {
        PL_NONE  = 2'd0,
        PL_ZERO  = 2'd1,
        PL_INDEX = 2'd2
    } pl_trig_e;

    localparam int NUM_HW_EV  = 4;
    localparam int NUM_REASON = NUM_HW_EV + 1;
    localparam int EV_INDEX   = 0;
    localparam int EV_MATCH   = 1;
    localparam int EV_ZERO    = 2;
    localparam int EV_QERR    = 3;
    localparam int EV_FORCE   = 4;
endpackage

// File: rtl/qcnt_decode.sv
// Count-step decoder. Turns encoder phases, a pulse/direction pair or an
// internal tick into one-cycle up/down strobes and an illegal-transition flag.
// Assumes phase inputs are already synchronized to clk. The previous-phase
// registers carry no reset because they only pipeline input data.
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic       clk,
    input  logic       run,
    input  logic [1:0] clk_mode,
    input  logic       phase_a,
    input  logic       phase_b,
    input  logic       tick,
    output logic       step_up,
    output logic       step_dn,
    output logic       qerr,
    output logic       floor_zero
);
    logic      a_q, b_q;
    logic [1:0] pos_q, pos_d, delta;
    logic      a_rise;
    clk_mode_e mode;

    assign mode = clk_mode_e'(clk_mode);

    // Remember the phase pair of the previous cycle.
    always_ff @(posedge clk) begin
        a_q <= phase_a;
        b_q <= phase_b;
    end

    // Decode a step from the old and new phase values.
    always_comb begin
        pos_q   = {b_q, a_q ^ b_q};
        pos_d   = {phase_b, phase_a ^ phase_b};
        delta   = pos_d - pos_q;
        a_rise  = phase_a & ~a_q;
        step_up = 1'b0;
        step_dn = 1'b0;
        qerr    = 1'b0;
        case (mode)
            CLK_QUAD: begin
                step_up = run && (delta == 2'd1);
                step_dn = run && (delta == 2'd3);
                qerr    = run && (delta == 2'd2);
            end
            CLK_SINGLE: begin
                step_up = run && a_rise && !phase_b;
                step_dn = run && a_rise && phase_b;
            end
            CLK_TICK: begin
                step_dn = run && tick;
            end
            default: ;
        endcase
        floor_zero = (mode == CLK_TICK);
    end
endmodule

// File: rtl/qcnt_ixsel.sv
// Index source selector and rising-edge detector. Source 0 is the external
// index, 1 its inverse, and 2 upward the neighbouring channel outputs.
// The edge strobe is only produced while the channel runs.
module qcnt_ixsel #(
    parameter int NPEER = 6,
    localparam int IXW  = $clog2(NPEER + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IXW-1:0]   ix_src,
    input  logic             index_ext,
    input  logic [NPEER-1:0] peer_out,
    output logic             ix_ev
);
    logic ix, ix_q;

    // Pick the selected index signal.
    always_comb begin
        ix = index_ext;
        if (ix_src == IXW'(1)) ix = ~index_ext;
        for (int k = 0; k < NPEER; k++) begin
            if (ix_src == IXW'(k + 2)) ix = peer_out[k];
        end
    end

    // Keep last cycle's selected index for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ix_q <= 1'b0;
        else        ix_q <= ix;
    end

    assign ix_ev = run & ix & ~ix_q;
endmodule

// File: rtl/qcnt_core.sv
// Counter core: applies count steps, reloads and match detection.
// Internal-tick mode floors at zero; other modes wrap. A reload overrides a
// step in the same cycle. The permissive bit admits a reload only when idle.
module qcnt_core
    import qcnt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         floor_zero,
    input  logic         ix_ev,
    input  logic [1:0]   pl_trig,
    input  logic         pl_alt,
    input  logic         pl_permissive,
    input  logic [W-1:0] preload0,
    input  logic [W-1:0] preload1,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    input  logic         cmp_sel,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         ev_match,
    output logic         ev_zero
);
    logic [W-1:0] stepped, pl_val, cmp_val;
    logic         pl_sel, at_zero, moving, reach_zero, pl_req, do_pl;
    pl_trig_e     trig;

    assign trig = pl_trig_e'(pl_trig);

    // Work out the next count and the events of this cycle.
    always_comb begin
        cmp_val    = cmp_sel ? cmp1 : cmp0;
        pl_val     = pl_sel ? preload1 : preload0;
        at_zero    = (count == '0);
        moving     = step_up | (step_dn & ~(floor_zero & at_zero));
        stepped    = step_up ? count + W'(1) : count - W'(1);
        reach_zero = moving && (stepped == '0);
        case (trig)
            PL_ZERO:  pl_req = reach_zero;
            PL_INDEX: pl_req = ix_ev;
            default:  pl_req = 1'b0;
        endcase
        do_pl      = pl_req && (!pl_permissive || at_zero || reach_zero);
        count_next = do_pl ? pl_val : (moving ? stepped : count);
        ev_zero    = reach_zero;
        ev_match   = moving && (stepped == cmp_val);
    end

    // Hold the count and the reload selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            pl_sel <= 1'b0;
        end else begin
            count <= count_next;
            if (do_pl && pl_alt) pl_sel <= ~pl_sel;
        end
    end
endmodule

// File: rtl/qcnt_snapq.sv
// Capture queue: DEPTH entries of DW bits with a show-ahead head.
// DEPTH must be a power of two. A push into a full queue is dropped and
// flags overflow unless a pop frees a slot in the same cycle; any pop clears it.
module qcnt_snapq #(
    parameter int DEPTH = 16,
    parameter int DW    = 69,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic          overflow
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   fill;
    logic          full, pop_ok, accept;

    assign valid  = (fill != '0);
    assign full   = (fill == (AW+1)'(DEPTH));
    assign pop_ok = pop && valid;
    assign accept = push && (!full || pop_ok);
    assign dout   = mem[rp];

    // Store accepted captures.
    always_ff @(posedge clk) begin
        if (accept) mem[wp] <= din;
    end

    // Track pointers, fill level and the drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            fill     <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wp <= wp + AW'(1);
            if (pop_ok) rp <= rp + AW'(1);
            case ({accept, pop_ok})
                2'b10:   fill <= fill + (AW+1)'(1);
                2'b01:   fill <= fill - (AW+1)'(1);
                default: ;
            endcase
            if (pop_ok)              overflow <= 1'b0;
            else if (push && !accept) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/qcnt_channel.sv
// Top of one counting channel with atomic captures. Combines the step decoder,
// index selector, counter core, arming of capture enables, a free-running
// stamp and the capture queue. Captures record the post-edge count.
module qcnt_channel
    import qcnt_pkg::*;
#(
    parameter int W      = 32,
    parameter int QDEPTH = 16,
    parameter int NPEER  = 6,
    localparam int IXW   = $clog2(NPEER + 2),
    localparam int DW    = 2 * W + NUM_REASON
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [1:0]            clk_mode,
    input  logic                  phase_a,
    input  logic                  phase_b,
    input  logic                  tick,
    input  logic                  index_ext,
    input  logic [NPEER-1:0]      peer_out,
    input  logic [IXW-1:0]        ix_src,
    input  logic [1:0]            pl_trig,
    input  logic                  pl_alt,
    input  logic                  pl_permissive,
    input  logic [W-1:0]          preload0,
    input  logic [W-1:0]          preload1,
    input  logic [W-1:0]          cmp0,
    input  logic [W-1:0]          cmp1,
    input  logic                  cmp_sel,
    input  logic [NUM_HW_EV-1:0]  snap_en,
    input  logic [NUM_HW_EV-1:0]  snap_sticky,
    input  logic                  snap_load,
    input  logic                  force_snap,
    input  logic                  rd_en,
    output logic [W-1:0]          count,
    output logic                  rd_valid,
    output logic [W-1:0]          rd_count,
    output logic [W-1:0]          rd_stamp,
    output logic [NUM_REASON-1:0] rd_reason,
    output logic                  overflow
);
    logic                  step_up, step_dn, qerr, floor_zero, ix_ev;
    logic                  ev_match, ev_zero, push;
    logic [W-1:0]          count_next, stamp;
    logic [NUM_HW_EV-1:0]  hw_ev, armed, fired;
    logic [NUM_REASON-1:0] reason;
    logic [DW-1:0]         q_din, q_dout;

    qcnt_decode i_decode (
        .clk(clk), .run(run), .clk_mode(clk_mode),
        .phase_a(phase_a), .phase_b(phase_b), .tick(tick),
        .step_up(step_up), .step_dn(step_dn), .qerr(qerr), .floor_zero(floor_zero)
    );

    qcnt_ixsel #(.NPEER(NPEER)) i_ixsel (
        .clk(clk), .rst_n(rst_n), .run(run), .ix_src(ix_src),
        .index_ext(index_ext), .peer_out(peer_out), .ix_ev(ix_ev)
    );

    qcnt_core #(.W(W)) i_core (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .floor_zero(floor_zero), .ix_ev(ix_ev), .pl_trig(pl_trig),
        .pl_alt(pl_alt), .pl_permissive(pl_permissive),
        .preload0(preload0), .preload1(preload1), .cmp0(cmp0), .cmp1(cmp1),
        .cmp_sel(cmp_sel), .count(count), .count_next(count_next),
        .ev_match(ev_match), .ev_zero(ev_zero)
    );

    // Collect hardware events in reason-bit order and form the capture.
    always_comb begin
        hw_ev            = '0;
        hw_ev[EV_INDEX]  = ix_ev;
        hw_ev[EV_MATCH]  = ev_match;
        hw_ev[EV_ZERO]   = ev_zero;
        hw_ev[EV_QERR]   = qerr;
        fired            = hw_ev & armed;
        reason           = {force_snap, fired};
        push             = (|fired) | force_snap;
        q_din            = {count_next, stamp, reason};
    end

    // Arm enables on load; consume non-sticky enables when they fire.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= '0;
        else if (snap_load) armed <= snap_en;
        else                armed <= armed & ~(fired & ~snap_sticky);
    end

    // Free-running capture stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + W'(1);
    end

    qcnt_snapq #(.DEPTH(QDEPTH), .DW(DW)) i_snapq (
        .clk(clk), .rst_n(rst_n), .push(push), .din(q_din), .pop(rd_en),
        .dout(q_dout), .valid(rd_valid), .overflow(overflow)
    );

    assign rd_count  = q_dout[DW-1 -: W];
    assign rd_stamp  = q_dout[NUM_REASON +: W];
    assign rd_reason = q_dout[NUM_REASON-1:0];
endmodule

// File: rtl/qcnt_channel_chk.sv
// Property checker for qcnt_channel, attached by bind. Observes ports only.
module qcnt_channel_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic [1:0]   clk_mode,
    input logic         phase_a,
    input logic         phase_b,
    input logic [1:0]   pl_trig,
    input logic         force_snap,
    input logic [W-1:0] count,
    input logic         rd_valid,
    input logic [4:0]   rd_reason,
    input logic         overflow
);
    assert_hold_halt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == $past(count));

    assert_qerr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clk_mode == 2'd0 && pl_trig != 2'd2 &&
         phase_a != $past(phase_a) && phase_b != $past(phase_b))
        |=> count == $past(count));

    assert_floor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && clk_mode == 2'd2 && pl_trig == 2'd0 && count == '0) |=> count == '0);

    assert_force_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        force_snap |=> rd_valid);

    assert_reason_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_reason != '0);

    assert_no_overflow_empty_R14: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> rd_valid);
endmodule

bind qcnt_channel qcnt_channel_chk #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_mode(clk_mode),
    .phase_a(phase_a), .phase_b(phase_b), .pl_trig(pl_trig),
    .force_snap(force_snap), .count(count), .rd_valid(rd_valid),
    .rd_reason(rd_reason), .overflow(overflow)
);

// File: tb/test_qcnt_channel.sv
`timescale 1ns/1ps
module test_qcnt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  clk_mode = 2'd0;
    logic        phase_a = 1'b0, phase_b = 1'b0, tick = 1'b0;
    logic        index_ext = 1'b0;
    logic [5:0]  peer_out = '0;
    logic [2:0]  ix_src = '0;
    logic [1:0]  pl_trig = '0;
    logic        pl_alt = 1'b0, pl_permissive = 1'b0;
    logic [31:0] preload0 = '0, preload1 = '0, cmp0 = '0, cmp1 = '0;
    logic        cmp_sel = 1'b0;
    logic [3:0]  snap_en = '0, snap_sticky = '0;
    logic        snap_load = 1'b0, force_snap = 1'b0, rd_en = 1'b0;
    logic [31:0] count, rd_count, rd_stamp;
    logic        rd_valid, overflow;
    logic [4:0]  rd_reason;

    int          nchecks = 0;
    int          nerrors = 0;
    int          cyc = 0;
    logic [31:0] last_stamp, s0;
    int          t1, t2;

    qcnt_channel i_qcnt_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_mode(clk_mode),
        .phase_a(phase_a), .phase_b(phase_b), .tick(tick),
        .index_ext(index_ext), .peer_out(peer_out), .ix_src(ix_src),
        .pl_trig(pl_trig), .pl_alt(pl_alt), .pl_permissive(pl_permissive),
        .preload0(preload0), .preload1(preload1), .cmp0(cmp0), .cmp1(cmp1),
        .cmp_sel(cmp_sel), .snap_en(snap_en), .snap_sticky(snap_sticky),
        .snap_load(snap_load), .force_snap(force_snap), .rd_en(rd_en),
        .count(count), .rd_valid(rd_valid), .rd_count(rd_count),
        .rd_stamp(rd_stamp), .rd_reason(rd_reason), .overflow(overflow)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // {clk_mode, phase_a, phase_b, expected count}
    localparam logic [35:0] STEPS [14] = '{
        {2'd0, 1'b1, 1'b0, 32'd1},
        {2'd0, 1'b1, 1'b1, 32'd2},
        {2'd0, 1'b0, 1'b1, 32'd3},
        {2'd0, 1'b0, 1'b0, 32'd4},
        {2'd0, 1'b0, 1'b1, 32'd3},
        {2'd0, 1'b1, 1'b1, 32'd2},
        {2'd0, 1'b1, 1'b0, 32'd1},
        {2'd0, 1'b0, 1'b0, 32'd0},
        {2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF},
        {2'd0, 1'b0, 1'b0, 32'd0},
        {2'd1, 1'b1, 1'b0, 32'd1},
        {2'd1, 1'b0, 1'b0, 32'd1},
        {2'd1, 1'b1, 1'b1, 32'd0},
        {2'd1, 1'b0, 1'b1, 32'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pop_chk(input string req, input logic [31:0] ecnt, input logic [4:0] erea);
        chk(req, rd_valid, 1);
        chk(req, rd_count, ecnt);
        chk(req, rd_reason, erea);
        last_stamp = rd_stamp;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load_arm(input logic [3:0] en, input logic [3:0] st);
        snap_en = en;
        snap_sticky = st;
        snap_load = 1'b1;
        @(negedge clk);
        snap_load = 1'b0;
    endtask

    task automatic pulse_ix();
        index_ext = 1'b1;
        @(negedge clk);
        index_ext = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchecks++;
        nerrors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", count, 0);
        chk("R1", rd_valid, 0);
        chk("R1", overflow, 0);

        // R2 / R4: table of encoder and single-phase steps
        run = 1'b1;
        for (int i = 0; i < 14; i++) begin
            clk_mode = STEPS[i][35:34];
            phase_a  = STEPS[i][33];
            phase_b  = STEPS[i][32];
            @(negedge clk);
            chk(i < 10 ? "R2" : "R4", count, STEPS[i][31:0]);
        end
        phase_a = 1'b1; phase_b = 1'b1;      // single-phase rise, down
        @(negedge clk);
        chk("R4", count, 32'hFFFF_FFFF);
        phase_a = 1'b0; phase_b = 1'b0;
        @(negedge clk);

        // R3: illegal encoder transitions, sticky arming (R12)
        clk_mode = 2'd0;
        load_arm(4'b1000, 4'b1000);
        phase_a = 1'b1; phase_b = 1'b1; t1 = cyc;
        @(negedge clk);
        chk("R3", count, 32'hFFFF_FFFF);
        phase_a = 1'b0; phase_b = 1'b0; t2 = cyc;
        @(negedge clk);
        chk("R3", count, 32'hFFFF_FFFF);
        pop_chk("R3", 32'hFFFF_FFFF, 5'b01000);
        s0 = last_stamp;
        pop_chk("R12", 32'hFFFF_FFFF, 5'b01000);
        chk("R11", last_stamp - s0, 32'(t2 - t1));
        chk("R3", rd_valid, 0);
        clk_mode = 2'd1;                      // double change is no error here
        phase_a = 1'b1; phase_b = 1'b1;
        @(negedge clk);
        chk("R4", count, 32'hFFFF_FFFE);
        chk("R3", rd_valid, 0);
        phase_a = 1'b0; phase_b = 1'b0;
        @(negedge clk);
        load_arm(4'b0000, 4'b0000);

        // R6: index reload
        clk_mode = 2'd2; pl_trig = 2'd2; preload0 = 32'd3;
        pulse_ix();
        chk("R6", count, 3);

        // R5: tick counts down, floors at zero, one-shot zero capture
        load_arm(4'b0100, 4'b0000);
        tick = 1'b1;
        @(negedge clk); chk("R5", count, 2);
        @(negedge clk); chk("R5", count, 1);
        @(negedge clk); chk("R5", count, 0);
        @(negedge clk); chk("R5", count, 0);
        tick = 1'b0;
        pop_chk("R5", 0, 5'b00100);
        chk("R5", rd_valid, 0);
        // R12: one-shot enable already consumed
        pulse_ix();
        run_ticks(3);
        chk("R12", count, 0);
        chk("R12", rd_valid, 0);

        // R7: permissive reload
        pl_permissive = 1'b1;
        pulse_ix();
        chk("R7", count, 3);
        run_ticks(1);
        chk("R7", count, 2);
        pulse_ix();
        chk("R7", count, 2);
        pl_permissive = 1'b0;
        pulse_ix();
        chk("R7", count, 3);

        // R6: alternating reload source
        pl_alt = 1'b1; preload1 = 32'd7;
        pulse_ix();
        chk("R6", count, 3);
        pulse_ix();
        chk("R6", count, 7);
        pl_alt = 1'b0;

        // R6: reload on reaching zero
        preload0 = 32'd1;
        pulse_ix();
        chk("R6", count, 1);
        pl_trig = 2'd1; preload0 = 32'd2;
        tick = 1'b1;
        @(negedge clk); chk("R6", count, 2);
        @(negedge clk); chk("R6", count, 1);
        @(negedge clk); chk("R6", count, 2);
        tick = 1'b0;

        // R8: compare match on the selected register only
        pl_trig = 2'd2; preload0 = 32'd3; cmp0 = 32'd1; cmp1 = 32'd2; cmp_sel = 1'b1;
        load_arm(4'b0010, 4'b0010);
        pulse_ix();
        run_ticks(3);
        cmp_sel = 1'b0;
        pulse_ix();
        run_ticks(3);
        pop_chk("R8", 2, 5'b00010);
        pop_chk("R8", 1, 5'b00010);
        chk("R8", rd_valid, 0);

        // R9: index source selection
        pl_trig = 2'd0; ix_src = 3'd3;
        load_arm(4'b0001, 4'b0001);
        peer_out[1] = 1'b1;
        @(negedge clk);
        peer_out[1] = 1'b0;
        @(negedge clk);
        pop_chk("R9", 0, 5'b00001);
        pulse_ix();
        chk("R9", rd_valid, 0);
        index_ext = 1'b1;
        @(negedge clk);
        ix_src = 3'd1;
        @(negedge clk);
        chk("R9", rd_valid, 0);
        index_ext = 1'b0;
        @(negedge clk);
        pop_chk("R9", 0, 5'b00001);
        ix_src = 3'd0;
        @(negedge clk);
        chk("R9", rd_valid, 0);
        load_arm(4'b0000, 4'b0000);

        // R13: halted channel ignores ticks and index
        pl_trig = 2'd2; preload0 = 32'd5;
        pulse_ix();
        chk("R13", count, 5);
        run = 1'b0;
        tick = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13", count, 5);
        pulse_ix();
        chk("R13", count, 5);
        run = 1'b1;
        @(negedge clk);
        chk("R13", count, 4);
        tick = 1'b0;

        // R10: forced capture while halted
        run = 1'b0;
        force_snap = 1'b1;
        @(negedge clk);
        force_snap = 1'b0;
        pop_chk("R10", 4, 5'b10000);

        // R14 / R11: fill past depth, drops, consecutive stamps
        chk("R14", rd_valid, 0);
        force_snap = 1'b1;
        repeat (18) @(negedge clk);
        force_snap = 1'b0;
        chk("R14", rd_valid, 1);
        chk("R14", overflow, 1);
        pop_chk("R14", 4, 5'b10000);
        s0 = last_stamp;
        chk("R14", overflow, 0);
        for (int k = 1; k < 16; k++) begin
            pop_chk("R14", 4, 5'b10000);
            chk("R11", last_stamp, s0 + 32'(k));
        end
        chk("R14", rd_valid, 0);

        report();
    end
endmodule